// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page translations for a 32-bit logical address space. A request carries a logical address, a privilege flag (supervisor or user) and a direction flag (read or write). One of three things then happens. On a hit, the block returns a physical address in the next cycle. If the cached page forbids the access, it returns a protection fault instead. On a miss, it stops accepting requests and asks an external table walker for the page descriptor.

When the walker answers, the descriptor is written into one of four ways of the selected set. The stalled access then finishes with the new translation, and its protection check uses the new descriptor. The walker itself is outside the block.

A static page-size input selects 4 KB or 8 KB pages. The set index is always the four address bits just above the page offset. A translation-off input makes the block pass addresses straight through. A flush input drops every cached translation in a single cycle.

Top module: `atc_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `walk_req` are 0, `req_ready` is 1 and no translation is cached.
- R2: A request that hits returns `rsp_valid` exactly one cycle after it is accepted. With 4 KB pages the physical address is {ppn[19:0], va[11:0]}, and no walk is issued.
- R3: With `page_8k`=1, the offset is va[12:0] and passes through untranslated, and the physical address is {ppn[19:1], va[12:0]}. The set index moves to va[16:13]. Two addresses that differ only in bit 12 share one cached entry.
- R4: If a page is marked supervisor-only and `req_super`=0, the response has `rsp_fault`=1, with `rsp_paddr` and `rsp_cmode` forced to 0.
- R5: If a page is marked write-protected and `req_write`=1, the response has `rsp_fault`=1, whatever the privilege level.
- R6: A faulting hit leaves the cache unchanged. A permitted access to the same page afterwards hits with no walk.
- R7: On a miss, `walk_req` rises in the cycle after acceptance, with `walk_vaddr` equal to the logical address. `req_ready` stays 0 until `walk_done`. The response follows one cycle after `walk_done` and uses the supplied descriptor, including its protection check.
- R8: A descriptor delivered by the walker is installed, so the next access to that page hits with no walk.
- R9: With `xlate_off`=1, a request returns `rsp_paddr` equal to the logical address, with `rsp_fault`=0 and `rsp_cmode`=0, one cycle after acceptance and without a walk.
- R10: A one-cycle `flush` pulse invalidates every entry. The next access to any previously cached page issues a walk.
- R11: Fills go to an invalid way first, so four distinct pages of one set all stay cached. A fifth page in that set evicts one of them, chosen by a free-running 2-bit counter.
- R12: A permitted translation returns the page's 2-bit cache mode on `rsp_cmode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_8k | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB pages |
| xlate_off | input | 1 | Bypass translation |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Logical address |
| req_super | input | 1 | 1 = supervisor access |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Protection fault |
| rsp_cmode | output | 2 | Cache mode of the page (0 on fault or bypass) |
| walk_req | output | 1 | Walk request, held until answered |
| walk_vaddr | output | 32 | Logical address to be walked |
| walk_done | input | 1 | Descriptor valid strobe from walker |
| walk_ppn | input | 20 | Physical page number in 4 KB units |
| walk_super | input | 1 | Page is supervisor-only |
| walk_wprot | input | 1 | Page is write-protected |
| walk_cmode | input | 2 | Cache mode of the page |

## Verification
The bench sends the same page first as a user and then as a supervisor, and as a write and then as a read. A design that updated or dropped the entry on a fault would show an unexpected second walk. In 8 KB mode it touches both halves of a page. An index taken from the wrong bits, or a tag that still compared bit 12, would walk twice or return the wrong offset.

It fills one set with four pages and probes them, then adds a fifth. Replacement that ignored invalid ways would lose one of the first four too early. It also varies the walker's delay, so a block that left the stall early would respond with a stale translation. Random traffic then mixes page-size changes, flushes and bypass requests, and every response is checked against a page table that the bench computes itself.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam int unsigned ATC_VA_W  = 32;
  localparam int unsigned ATC_PG_LO = 12;
  localparam int unsigned ATC_VPN_W = ATC_VA_W - ATC_PG_LO;
  localparam int unsigned ATC_CM_W  = 2;
  localparam int unsigned ATC_WAYS  = 4;
  localparam int unsigned ATC_SETS  = 16;

  typedef struct packed {
    logic                 big;
    logic [ATC_VPN_W-1:0] vpn;
    logic [ATC_VPN_W-1:0] ppn;
    logic                 sup;
    logic                 wp;
    logic [ATC_CM_W-1:0]  cm;
  } atc_ent_t;

  // page key: bit 0 of the 4 KB page number is dropped for large pages
  function automatic logic [ATC_VPN_W-1:0] page_of(logic [ATC_VA_W-1:0] va, logic big);
    logic [ATC_VPN_W-1:0] p;
    p = va[ATC_VA_W-1:ATC_PG_LO];
    if (big) p[0] = 1'b0;
    return p;
  endfunction

  // physical address: offset bits come straight from the logical address
  function automatic logic [ATC_VA_W-1:0] join_pa(logic [ATC_VPN_W-1:0] ppn,
                                                  logic [ATC_VA_W-1:0] va, logic big);
    logic [ATC_VA_W-1:0] pa;
    pa = {ppn, va[ATC_PG_LO-1:0]};
    if (big) pa[ATC_PG_LO] = va[ATC_PG_LO];
    return pa;
  endfunction

  function automatic logic access_bad(logic sup_only, logic wp, logic is_sup, logic is_wr);
    return (sup_only && !is_sup) || (wp && is_wr);
  endfunction
endpackage

// File: rtl/atc_victim.sv
module atc_victim #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  set_vld,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] rnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd <= '0;
    else        rnd <= rnd + 1'b1;
  end

  // lowest-numbered empty way wins, else the counter picks
  always_comb begin
    victim = rnd;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!set_vld[i]) victim = WAY_W'(i);
    end
  end
endmodule

// File: rtl/atc_array.sv
module atc_array
  import atc_pkg::*;
#(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 16,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [IDX_W-1:0]     lk_idx,
  input  logic [ATC_VPN_W-1:0] lk_page,
  input  logic                 lk_big,
  output logic [WAYS-1:0]      hit_vec,
  output atc_ent_t             hit_ent,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WAY_W-1:0]     wr_way,
  input  atc_ent_t             wr_ent,
  output logic [WAYS-1:0]      wr_set_vld
);
  atc_ent_t rd_ents [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] vld;
    atc_ent_t        mem [SETS];
    logic            sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= '0;
      end else begin
        if (flush) vld <= '0;
        if (sel)   vld[wr_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) mem[wr_idx] <= wr_ent;
    end

    assign rd_ents[w]    = mem[lk_idx];
    assign hit_vec[w]    = vld[lk_idx] && (rd_ents[w].big == lk_big) &&
                           (rd_ents[w].vpn == lk_page);
    assign wr_set_vld[w] = vld[wr_idx];
  end

  always_comb begin
    hit_ent = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_ent = hit_ent | rd_ents[w];
    end
  end
endmodule

// File: rtl/atc_xlate.sv
module atc_xlate
  import atc_pkg::*;
#(
  parameter int unsigned WAYS = ATC_WAYS,
  parameter int unsigned SETS = ATC_SETS,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 page_8k,
  input  logic                 xlate_off,
  input  logic                 flush,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ATC_VA_W-1:0]  req_vaddr,
  input  logic                 req_super,
  input  logic                 req_write,
  output logic                 rsp_valid,
  output logic [ATC_VA_W-1:0]  rsp_paddr,
  output logic                 rsp_fault,
  output logic [ATC_CM_W-1:0]  rsp_cmode,
  output logic                 walk_req,
  output logic [ATC_VA_W-1:0]  walk_vaddr,
  input  logic                 walk_done,
  input  logic [ATC_VPN_W-1:0] walk_ppn,
  input  logic                 walk_super,
  input  logic                 walk_wprot,
  input  logic [ATC_CM_W-1:0]  walk_cmode
);
  typedef enum logic {ST_IDLE, ST_WALK} st_t;

  function automatic logic [IDX_W-1:0] idx_of(logic [ATC_VA_W-1:0] va, logic big);
    logic [ATC_VA_W-1:0] sh;
    sh = big ? (va >> (ATC_PG_LO + 1)) : (va >> ATC_PG_LO);
    return sh[IDX_W-1:0];
  endfunction

  st_t                 state;
  logic [ATC_VA_W-1:0] pend_va;
  logic                pend_sup, pend_wr, pend_big;

  logic                 accept;
  logic [IDX_W-1:0]     lk_idx, fill_idx;
  logic [ATC_VPN_W-1:0] lk_page;
  logic [WAYS-1:0]      hit_vec, fill_set_vld;
  logic                 lookup_hit;
  atc_ent_t             hit_ent, fill_ent;
  logic                 fill_we;
  logic [WAY_W-1:0]     fill_way;
  logic                 hit_bad, fill_bad;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign walk_req   = (state == ST_WALK);
  assign walk_vaddr = pend_va;

  assign lk_idx     = idx_of(req_vaddr, page_8k);
  assign lk_page    = page_of(req_vaddr, page_8k);
  assign lookup_hit = |hit_vec;
  assign hit_bad    = access_bad(hit_ent.sup, hit_ent.wp, req_super, req_write);

  assign fill_we    = walk_req && walk_done;
  assign fill_idx   = idx_of(pend_va, pend_big);
  assign fill_bad   = access_bad(walk_super, walk_wprot, pend_sup, pend_wr);
  assign fill_ent   = '{big: pend_big, vpn: page_of(pend_va, pend_big), ppn: walk_ppn,
                        sup: walk_super, wp: walk_wprot, cm: walk_cmode};

  atc_array #(.WAYS(WAYS), .SETS(SETS)) i_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_idx     (lk_idx),
    .lk_page    (lk_page),
    .lk_big     (page_8k),
    .hit_vec    (hit_vec),
    .hit_ent    (hit_ent),
    .wr_en      (fill_we),
    .wr_idx     (fill_idx),
    .wr_way     (fill_way),
    .wr_ent     (fill_ent),
    .wr_set_vld (fill_set_vld)
  );

  atc_victim #(.WAYS(WAYS)) i_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vld (fill_set_vld),
    .victim  (fill_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_va   <= '0;
      pend_sup  <= 1'b0;
      pend_wr   <= 1'b0;
      pend_big  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cmode <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (xlate_off) begin
              rsp_valid <= 1'b1;
              rsp_paddr <= req_vaddr;
              rsp_fault <= 1'b0;
              rsp_cmode <= '0;
            end else if (lookup_hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= hit_bad;
              rsp_paddr <= hit_bad ? '0 : join_pa(hit_ent.ppn, req_vaddr, page_8k);
              rsp_cmode <= hit_bad ? '0 : hit_ent.cm;
            end else begin
              state    <= ST_WALK;
              pend_va  <= req_vaddr;
              pend_sup <= req_super;
              pend_wr  <= req_write;
              pend_big <= page_8k;
            end
          end
        end
        ST_WALK: begin
          if (walk_done) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_fault <= fill_bad;
            rsp_paddr <= fill_bad ? '0 : join_pa(walk_ppn, pend_va, pend_big);
            rsp_cmode <= fill_bad ? '0 : walk_cmode;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atc_xlate_chk.sv
module atc_xlate_chk #(
  parameter int unsigned WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xlate_off,
  input logic            flush,
  input logic            req_valid,
  input logic            req_ready,
  input logic [31:0]     req_vaddr,
  input logic            rsp_valid,
  input logic [31:0]     rsp_paddr,
  input logic            rsp_fault,
  input logic            walk_req,
  input logic            walk_done,
  input logic [WAYS-1:0] hit_vec,
  input logic            lookup_hit,
  input logic            fill_we
);
  logic accept;
  assign accept = req_valid && req_ready;

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xlate_off && lookup_hit |=> rsp_valid && !walk_req); // R2
  AST_MISS_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xlate_off && !lookup_hit |=> walk_req && !rsp_valid); // R7
  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready); // R7
  AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !walk_done |=> walk_req); // R7
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && walk_done |=> rsp_valid && !walk_req); // R8
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xlate_off |=> rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr)); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !fill_we |=> hit_vec == '0); // R10
  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R11
endmodule

bind atc_xlate atc_xlate_chk #(.WAYS(WAYS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xlate_off  (xlate_off),
  .flush      (flush),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vaddr  (req_vaddr),
  .rsp_valid  (rsp_valid),
  .rsp_paddr  (rsp_paddr),
  .rsp_fault  (rsp_fault),
  .walk_req   (walk_req),
  .walk_done  (walk_done),
  .hit_vec    (hit_vec),
  .lookup_hit (lookup_hit),
  .fill_we    (fill_we)
);

// File: tb/test_atc_xlate.sv
`timescale 1ns/1ps
module test_atc_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_8k = 1'b0, xlate_off = 1'b0, flush = 1'b0;
  logic        req_valid = 1'b0, req_super = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault, walk_req;
  logic [31:0] rsp_paddr, walk_vaddr;
  logic [1:0]  rsp_cmode;
  logic        walk_done = 1'b0, walk_super = 1'b0, walk_wprot = 1'b0;
  logic [19:0] walk_ppn = '0;
  logic [1:0]  walk_cmode = '0;

  int n_cmp = 0, n_bad = 0;
  logic        walked;
  int          lat;
  logic [31:0] got_pa;
  logic        got_fault;
  logic [1:0]  got_cm;

  always #2 clk = ~clk;

  atc_xlate i_atc_xlate (
    .clk(clk), .rst_n(rst_n), .page_8k(page_8k), .xlate_off(xlate_off), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_super(req_super), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cmode(rsp_cmode),
    .walk_req(walk_req), .walk_vaddr(walk_vaddr), .walk_done(walk_done),
    .walk_ppn(walk_ppn), .walk_super(walk_super), .walk_wprot(walk_wprot),
    .walk_cmode(walk_cmode)
  );

  // bench page table, indexed by a 4 KB page key
  function automatic logic [19:0] key_of(logic [31:0] va, logic big);
    return big ? {va[31:13], 1'b0} : va[31:12];
  endfunction
  function automatic logic [19:0] d_ppn(logic [19:0] k); return (k * 20'd7) ^ 20'h3C5A1; endfunction
  function automatic logic d_sup(logic [19:0] k); return k[2] ^ k[6]; endfunction
  function automatic logic d_wp(logic [19:0] k);  return k[4] & k[1]; endfunction
  function automatic logic [1:0] d_cm(logic [19:0] k); return k[9:8]; endfunction

  function automatic logic [19:0] pick(int set, bit s, bit w, int skip);
    int left = skip;
    for (int k = 1; k < 4000; k++) begin
      logic [19:0] p = {k[15:0], set[3:0]};
      if (d_sup(p) == s && d_wp(p) == w) begin
        if (left == 0) return p;
        left--;
      end
    end
    return 20'h0;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic flush_all();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // one access, acting as walker on a miss with a random delay
  task automatic access(input logic [31:0] va, input logic s, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_super = s; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    walked = 1'b0; lat = 1;
    while (!rsp_valid && lat < 40) begin
      if (walk_req) begin
        logic [19:0] k = key_of(walk_vaddr, page_8k);
        walked = 1'b1;
        chk(walk_vaddr == va, "R7 walk address", walk_vaddr, va);
        chk(req_ready == 1'b0, "R7 stalled while walking", {31'd0, req_ready}, 32'd0);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        walk_done = 1'b1; walk_ppn = d_ppn(k); walk_super = d_sup(k);
        walk_wprot = d_wp(k); walk_cmode = d_cm(k);
        @(negedge clk);
        walk_done = 1'b0;
        lat++;
        chk(rsp_valid == 1'b1, "R7 response one cycle after walk_done", {31'd0, rsp_valid}, 32'd1);
      end else begin
        @(negedge clk);
        lat++;
      end
    end
    got_pa = rsp_paddr; got_fault = rsp_fault; got_cm = rsp_cmode;
  endtask

  task automatic expect_rsp(input string tag, input logic [31:0] va, input logic s, input logic w);
    logic [19:0] k = key_of(va, page_8k);
    logic [19:0] p = d_ppn(k);
    logic        f;
    logic [31:0] epa;
    logic [1:0]  ecm;
    if (xlate_off) begin
      f = 1'b0; epa = va; ecm = 2'd0;
    end else begin
      f   = (d_sup(k) && !s) || (d_wp(k) && w);
      epa = f ? 32'd0 : (page_8k ? {p[19:1], va[12:0]} : {p, va[11:0]});
      ecm = f ? 2'd0 : d_cm(k);
    end
    chk(got_fault == f, {tag, " fault"}, {31'd0, got_fault}, {31'd0, f});
    chk(got_pa == epa, {tag, " paddr"}, got_pa, epa);
    chk(got_cm == ecm, {tag, " R12 cmode"}, {30'd0, got_cm}, {30'd0, ecm});
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] va;
    logic [19:0] pg;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0 && walk_req == 1'b0 && req_ready == 1'b1, "R1 reset outputs",
        {29'd0, rsp_valid, walk_req, req_ready}, 32'd1);

    // R7 / R8 / R2: miss then hit on a plain 4 KB page
    pg = pick(3, 0, 0, 0); va = {pg, 12'h5A4};
    access(va, 1'b0, 1'b0);
    chk(walked, "R1 empty after reset so first access walks", {31'd0, walked}, 32'd1);
    expect_rsp("R7 fill", va, 1'b0, 1'b0);
    access(va ^ 32'h0000_0FF0, 1'b0, 1'b0);
    chk(!walked, "R8 installed page hits", {31'd0, walked}, 32'd0);
    chk(lat == 1, "R2 hit latency", lat, 1);
    expect_rsp("R2 hit", va ^ 32'h0000_0FF0, 1'b0, 1'b0);

    // R4 / R6: supervisor-only page
    pg = pick(6, 1, 0, 0); va = {pg, 12'h010};
    access(va, 1'b1, 1'b0); expect_rsp("R4 fill as supervisor", va, 1'b1, 1'b0);
    access(va, 1'b0, 1'b0);
    chk(got_fault == 1'b1, "R4 user on supervisor page", {31'd0, got_fault}, 32'd1);
    expect_rsp("R4", va, 1'b0, 1'b0);
    access(va, 1'b1, 1'b0);
    chk(!walked, "R6 entry kept after fault", {31'd0, walked}, 32'd0);
    expect_rsp("R6", va, 1'b1, 1'b0);

    // R5: write-protected page, including fault on the fill itself
    pg = pick(2, 0, 1, 0); va = {pg, 12'hABC};
    access(va, 1'b1, 1'b1);
    chk(got_fault == 1'b1, "R5 write on protected page (fill)", {31'd0, got_fault}, 32'd1);
    expect_rsp("R5 fill", va, 1'b1, 1'b1);
    access(va, 1'b0, 1'b1);
    chk(!walked && got_fault, "R5 write hit faults", {30'd0, walked, got_fault}, 32'd1);
    access(va, 1'b0, 1'b0);
    chk(!walked && !got_fault, "R6 read after write fault hits", {30'd0, walked, got_fault}, 32'd0);
    expect_rsp("R5 read", va, 1'b0, 1'b0);

    // R3: 8 KB pages, both halves share one entry
    @(negedge clk); page_8k = 1'b1;
    va = 32'h1234_6F00;
    access(va, 1'b1, 1'b0); expect_rsp("R3 8k fill", va, 1'b1, 1'b0);
    access(va ^ 32'h0000_1000, 1'b1, 1'b0);
    chk(!walked, "R3 other half of 8k page hits", {31'd0, walked}, 32'd0);
    expect_rsp("R3 8k offset", va ^ 32'h0000_1000, 1'b1, 1'b0);
    @(negedge clk); page_8k = 1'b0;

    // R9: bypass ignores protection and does not walk
    @(negedge clk); xlate_off = 1'b1;
    va = {pick(6, 1, 0, 1), 12'h777};
    access(va, 1'b0, 1'b1);
    chk(!walked && lat == 1, "R9 bypass no walk", {31'd0, walked}, 32'd0);
    expect_rsp("R9 bypass", va, 1'b0, 1'b1);
    @(negedge clk); xlate_off = 1'b0;

    // R10: flush forgets everything
    flush_all();
    va = {pick(3, 0, 0, 0), 12'h5A4};
    access(va, 1'b0, 1'b0);
    chk(walked, "R10 walk after flush", {31'd0, walked}, 32'd1);
    expect_rsp("R10", va, 1'b0, 1'b0);

    // R11: invalid ways fill first; a fifth page evicts one
    flush_all();
    for (int i = 0; i < 5; i++) begin
      va = {16'(i + 100), 4'd5, 12'h020};
      access(va, 1'b1, 1'b0);
      expect_rsp("R11 fill", va, 1'b1, 1'b0);
      if (i == 3) begin
        int misses = 0;
        for (int j = 0; j < 4; j++) begin
          access({16'(j + 100), 4'd5, 12'h020}, 1'b1, 1'b0);
          if (walked) misses++;
        end
        chk(misses == 0, "R11 four pages share a set", misses, 0);
      end
    end
    access({16'd104, 4'd5, 12'h020}, 1'b1, 1'b0);
    chk(!walked, "R11 newest page cached", {31'd0, walked}, 32'd0);
    begin
      bit found = 0;
      for (int j = 0; j < 4 && !found; j++) begin
        access({16'(j + 100), 4'd5, 12'h020}, 1'b1, 1'b0);
        if (walked) found = 1;
      end
      chk(found, "R11 one older page evicted", {31'd0, found}, 32'd1);
    end

    // random traffic over a small page pool
    for (int n = 0; n < 400; n++) begin
      logic s, w;
      if ($urandom_range(0, 31) == 0) flush_all();
      if ($urandom_range(0, 39) == 0) begin @(negedge clk); page_8k = ~page_8k; end
      @(negedge clk); xlate_off = ($urandom_range(0, 15) == 0);
      va = {12'($urandom_range(0, 5)), 4'($urandom_range(0, 3)), 4'($urandom_range(0, 1) * 3), 12'($urandom)};
      s = 1'($urandom); w = 1'($urandom);
      access(va, s, w);
      if (xlate_off) expect_rsp("R9 random", va, s, w);
      else if (walked) expect_rsp("R7 random", va, s, w);
      else expect_rsp("R2 random", va, s, w);
    end
    finish_run();
  end
endmodule